// File: doc/BRIEF.md
# Short-Address DMA Channel

This block is a single DMA channel that keeps one memory address of its own. The far end of every transfer is either a fixed peripheral register address or, in single-address mode, an external device that is selected by an acknowledge strobe instead of an address. Each accepted request moves one byte or one 16-bit word through a simple bus-master port and counts one transfer off a 16-bit count.

The channel is set up by a one-cycle start strobe that captures the memory address, peripheral address, count and mode bits, and enables the channel. The trigger comes from one selected source: six timer events, serial transmit-complete, serial receive-complete, converter end-of-conversion, or an external request pin. A trigger pulse is remembered until the channel serves it. When the count runs out, the channel either stops and raises its done interrupt, or, in repeat mode, reloads its start values and keeps going. A parameter marks the channel as the B half of a pair. Only a B channel honours the external pin and single-address mode.

The bus port holds `bus_req` and its address until `bus_ack` is sampled high on a rising edge. A dual-address unit is one read phase followed by one write phase that carries the read data.

Top module: `dma_short_chan`

## Requirements
- R1: A dual-address unit is one read phase at the source address followed by one write phase at the destination address. The write carries the data that was read. When `cfg_word`=0 only bits 7:0 are moved and bits 15:8 of `bus_wdata` are zero. `bus_word` reflects `cfg_word`. With `cfg_to_mem`=1 the source is the peripheral address and the destination is the memory address. With `cfg_to_mem`=0 it is the other way round.
- R2: In sequential mode (`cfg_mode`=2'b00) the memory address changes after each unit by 1 for bytes or 2 for words. It increases when `cfg_dec`=0 and decreases when `cfg_dec`=1.
- R3: In idle mode (`cfg_mode`=2'b01) the memory address stays the same for every unit.
- R4: A count of N (1 to 65535) allows exactly N units, and a count of 0 allows 65,536 units. When the last unit completes, `busy` falls and `done_irq` rises and stays high until the next start. Later requests cause no bus activity.
- R5: In repeat mode (`cfg_mode`=2'b10) the address steps as in sequential mode. When the count runs out, the address and count reload from their start values, `busy` stays high and `done_irq` stays low.
- R6: In single-address mode (`cfg_single`=1, B channel only) each unit is one bus phase at the memory address. `bus_wr` equals `cfg_to_mem` and `dack` is high for exactly that phase. `dack` is never high without `bus_req`.
- R7: A request pulse of one cycle that arrives while a unit is in progress is held and served after that unit.
- R8: A request that arrives while the channel is disabled (before a start or after `cfg_stop`) is dropped. It causes no transfer after a later start.
- R9: `cfg_src` picks the only source that triggers the channel: codes 0 to 5 are `evt_timer[0..5]`, 6 is `evt_tx`, 7 is `evt_rx`, 8 is `evt_adc`, and 9 is `ext_req`.
- R10: A channel built with `IS_CHAN_B`=0 ignores `ext_req` and treats `cfg_single` as 0.
- R11: After reset, `bus_req`, `dack`, `busy` and `done_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Load configuration and enable the channel |
| cfg_stop | input | 1 | Disable the channel |
| cfg_mem_addr | input | ADDR_W | Starting memory address |
| cfg_io_addr | input | ADDR_W | Fixed peripheral register address |
| cfg_count | input | CNT_W | Transfer count (0 means 2^CNT_W) |
| cfg_mode | input | 2 | 00 sequential, 01 idle, 10 repeat |
| cfg_word | input | 1 | 1 word units, 0 byte units |
| cfg_dec | input | 1 | Address steps downward when 1 |
| cfg_to_mem | input | 1 | 1 peripheral to memory, 0 memory to peripheral |
| cfg_single | input | 1 | Single-address (acknowledge) mode |
| cfg_src | input | SRC_W | Request source select |
| evt_timer | input | NUM_TMR | Timer compare/capture events |
| evt_tx | input | 1 | Serial transmit-complete event |
| evt_rx | input | 1 | Serial receive-complete event |
| evt_adc | input | 1 | Converter end-of-conversion event |
| ext_req | input | 1 | External request pin |
| bus_req | output | 1 | Bus phase request |
| bus_wr | output | 1 | Phase is a write |
| bus_word | output | 1 | Phase size is a word |
| bus_addr | output | ADDR_W | Phase address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data |
| bus_ack | input | 1 | Phase completes on this edge |
| dack | output | 1 | Acknowledge strobe for single-address mode |
| busy | output | 1 | Channel enabled |
| done_irq | output | 1 | Count expired (non-repeat modes) |

## Verification
A wrong address register shows at `bus_addr` on the next unit's first phase, a few cycles after the following request. A wrong count shows only when the expiry arrives: either one unit too early or one too late, or `done_irq` moves where it should not in repeat mode. So the vectors run each count to just past its end. A latch that keeps a stale request, or drops a held one, shows as extra or missing bus phases within about five cycles of the trigger. The bench therefore counts every phase rather than only the phases it expects.

// File: rtl/dma_short_pkg.sv
package dma_short_pkg;

  typedef enum logic [1:0] {
    MODE_SEQ    = 2'b00,
    MODE_IDLE   = 2'b01,
    MODE_REPEAT = 2'b10,
    MODE_RSVD   = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_READ   = 2'b01,
    ST_WRITE  = 2'b10,
    ST_SINGLE = 2'b11
  } bus_state_e;

  localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch #(
  parameter int NUM_TMR = 6,
  parameter int SRC_W   = 4,
  parameter bit EXT_OK  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               en,
  input  logic               accept,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic [NUM_TMR-1:0] evt_timer,
  input  logic               evt_tx,
  input  logic               evt_rx,
  input  logic               evt_adc,
  input  logic               ext_req,
  output logic               pend
);

  localparam int NUM_SRC = NUM_TMR + 4;

  logic               ext_gated;
  logic [NUM_SRC-1:0] src_vec;
  logic               hit;

  generate
    if (EXT_OK) begin : g_ext_on
      assign ext_gated = ext_req;
    end else begin : g_ext_off
      assign ext_gated = 1'b0;
    end
  endgenerate

  assign src_vec = {ext_gated, evt_adc, evt_rx, evt_tx, evt_timer};

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_sel == SRC_W'(i)) hit = src_vec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pend <= 1'b0;
    else            pend <= en & ((pend & ~accept) | hit);
  end

endmodule

// File: rtl/dma_mem_addr.sv
module dma_mem_addr #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_en,
  input  logic              reload,
  input  logic              hold,
  input  logic              word,
  input  logic              dec,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] step;

  assign step = word ? ADDR_W'(2) : ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      base_q <= '0;
    end else if (load) begin
      addr   <= load_val;
      base_q <= load_val;
    end else if (step_en) begin
      if (reload)     addr <= base_q;
      else if (!hold) addr <= dec ? (addr - step) : (addr + step);
    end
  end

endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  input  logic             reload,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] shadow_q;

  assign last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else if (load) begin
      cnt_q    <= load_val;
      shadow_q <= load_val;
    end else if (dec_en) begin
      if (reload) cnt_q <= shadow_q;
      else        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_short_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              go,
  input  logic              single,
  input  logic              to_mem,
  input  logic              word,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] rdata,
  input  logic              ack,
  output logic              req,
  output logic              wr,
  output logic              word_o,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              dack_o,
  output logic              seq_idle,
  output logic              unit_done
);

  bus_state_e st_q;

  function automatic logic [DATA_W-1:0] size_mask(input logic [DATA_W-1:0] d,
                                                  input logic w);
    logic [DATA_W-1:0] r;
    r = d;
    if (!w) r[DATA_W-1:BYTE_BITS] = '0;
    return r;
  endfunction

  assign seq_idle  = (st_q == ST_IDLE);
  assign unit_done = ((st_q == ST_WRITE) || (st_q == ST_SINGLE)) && ack;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st_q   <= ST_IDLE;
      req    <= 1'b0;
      wr     <= 1'b0;
      word_o <= 1'b0;
      addr   <= '0;
      wdata  <= '0;
      dack_o <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (go) begin
            req    <= 1'b1;
            word_o <= word;
            if (single) begin
              st_q   <= ST_SINGLE;
              addr   <= mem_addr;
              wr     <= to_mem;
              dack_o <= 1'b1;
            end else begin
              st_q <= ST_READ;
              addr <= to_mem ? io_addr : mem_addr;
              wr   <= 1'b0;
            end
          end
        end
        ST_READ: begin
          if (ack) begin
            st_q  <= ST_WRITE;
            addr  <= to_mem ? mem_addr : io_addr;
            wr    <= 1'b1;
            wdata <= size_mask(rdata, word_o);
          end
        end
        default: begin
          if (ack) begin
            st_q   <= ST_IDLE;
            req    <= 1'b0;
            wr     <= 1'b0;
            dack_o <= 1'b0;
            wdata  <= '0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dma_short_chan.sv
module dma_short_chan
  import dma_short_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16,
  parameter int NUM_TMR   = 6,
  parameter int SRC_W     = 4,
  parameter bit IS_CHAN_B = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_start,
  input  logic               cfg_stop,
  input  logic [ADDR_W-1:0]  cfg_mem_addr,
  input  logic [ADDR_W-1:0]  cfg_io_addr,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_word,
  input  logic               cfg_dec,
  input  logic               cfg_to_mem,
  input  logic               cfg_single,
  input  logic [SRC_W-1:0]   cfg_src,
  input  logic [NUM_TMR-1:0] evt_timer,
  input  logic               evt_tx,
  input  logic               evt_rx,
  input  logic               evt_adc,
  input  logic               ext_req,
  output logic               bus_req,
  output logic               bus_wr,
  output logic               bus_word,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  input  logic               bus_ack,
  output logic               dack,
  output logic               busy,
  output logic               done_irq
);

  addr_mode_e        mode_q;
  logic              word_q;
  logic              dec_q;
  logic              to_mem_q;
  logic              single_q;
  logic [SRC_W-1:0]  src_q;
  logic [ADDR_W-1:0] io_q;
  logic              en_q;
  logic              done_q;

  logic              single_eff;
  logic              pend;
  logic              seq_idle;
  logic              go;
  logic              unit_done;
  logic              cnt_last;
  logic              is_repeat;
  logic              hold_addr;
  logic              expire_reload;
  logic [ADDR_W-1:0] mem_addr;

  generate
    if (IS_CHAN_B) begin : g_single_ok
      assign single_eff = cfg_single;
    end else begin : g_single_off
      assign single_eff = 1'b0;
    end
  endgenerate

  assign is_repeat     = (mode_q == MODE_REPEAT);
  assign hold_addr     = (mode_q == MODE_IDLE) || (mode_q == MODE_RSVD);
  assign expire_reload = cnt_last && is_repeat;
  assign go            = seq_idle && en_q && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_SEQ;
      word_q   <= 1'b0;
      dec_q    <= 1'b0;
      to_mem_q <= 1'b0;
      single_q <= 1'b0;
      src_q    <= '0;
      io_q     <= '0;
      en_q     <= 1'b0;
      done_q   <= 1'b0;
    end else if (cfg_start) begin
      mode_q   <= addr_mode_e'(cfg_mode);
      word_q   <= cfg_word;
      dec_q    <= cfg_dec;
      to_mem_q <= cfg_to_mem;
      single_q <= single_eff;
      src_q    <= cfg_src;
      io_q     <= cfg_io_addr;
      en_q     <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      if (unit_done && cnt_last && !is_repeat) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
      end else if (cfg_stop) begin
        en_q <= 1'b0;
      end
    end
  end

  assign busy     = en_q;
  assign done_irq = done_q;

  dma_req_latch #(
    .NUM_TMR (NUM_TMR),
    .SRC_W   (SRC_W),
    .EXT_OK  (IS_CHAN_B)
  ) u_req (
    .clk       (clk),
    .rst       (rst),
    .clr       (cfg_start),
    .en        (en_q),
    .accept    (go),
    .src_sel   (src_q),
    .evt_timer (evt_timer),
    .evt_tx    (evt_tx),
    .evt_rx    (evt_rx),
    .evt_adc   (evt_adc),
    .ext_req   (ext_req),
    .pend      (pend)
  );

  dma_mem_addr #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_start),
    .load_val (cfg_mem_addr),
    .step_en  (unit_done),
    .reload   (expire_reload),
    .hold     (hold_addr),
    .word     (word_q),
    .dec      (dec_q),
    .addr     (mem_addr)
  );

  dma_xfer_count #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_start),
    .load_val (cfg_count),
    .dec_en   (unit_done),
    .reload   (expire_reload),
    .last     (cnt_last)
  );

  dma_bus_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .abort     (cfg_start),
    .go        (go),
    .single    (single_q),
    .to_mem    (to_mem_q),
    .word      (word_q),
    .mem_addr  (mem_addr),
    .io_addr   (io_q),
    .rdata     (bus_rdata),
    .ack       (bus_ack),
    .req       (bus_req),
    .wr        (bus_wr),
    .word_o    (bus_word),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .dack_o    (dack),
    .seq_idle  (seq_idle),
    .unit_done (unit_done)
  );

endmodule

// File: rtl/dma_short_chan_chk.sv
module dma_short_chan_chk
  import dma_short_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_start,
  input logic              cfg_stop,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_wr,
  input logic              bus_word,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              dack,
  input logic              busy,
  input logic              done_irq,
  input addr_mode_e        mode_q
);

  // R1: a phase keeps its address until it is acknowledged
  assert_addr_held_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !cfg_start) |=> (bus_req && $stable(bus_addr)));

  // R1: byte writes carry zero in the upper byte
  assert_byte_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_wr && !bus_word && !dack) |-> (bus_wdata[DATA_W-1:8] == '0));

  // R4: done only appears on a stopped channel
  assert_done_stops_R4: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> !busy);

  // R5: repeat mode never drops the enable by itself
  assert_repeat_stays_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q == MODE_REPEAT && !cfg_stop && !cfg_start) |=> busy);

  // R6: acknowledge strobe only inside a bus phase
  assert_dack_in_phase_R6: assert property (@(posedge clk) disable iff (rst)
    dack |-> bus_req);

  // R8: a disabled, quiet channel starts no phase
  assert_no_phase_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !bus_req) |=> !bus_req);

endmodule

bind dma_short_chan dma_short_chan_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_start (cfg_start),
  .cfg_stop  (cfg_stop),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_wr    (bus_wr),
  .bus_word  (bus_word),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .dack      (dack),
  .busy      (busy),
  .done_irq  (done_irq),
  .mode_q    (mode_q)
);

// File: tb/dma_short_chan_test.sv
`timescale 1ns/1ps
module dma_short_chan_test;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;
  localparam logic [ADDR_W-1:0] IO_ADDR = 24'h00F000;

  // vector: mode[47:46] word[45] dec[44] to_mem[43] single[42] src[41:38]
  //         maddr[37:22] count[21:6] nreq[5:0]
  localparam logic [47:0] VECS [8] = '{
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h1000, 16'd5, 6'd3}, // R1 R2 R9 seq byte up
    {2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6, 16'h2000, 16'd3, 6'd4}, // R2 R4 word down, expiry
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7, 16'h3000, 16'd2, 6'd3}, // R3 R4 idle
    {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 16'h4000, 16'd2, 6'd5}, // R5 repeat word
    {2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9, 16'h5000, 16'd2, 6'd2}, // R6 R9 single, ext pin
    {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 16'h5800, 16'd0, 6'd3}, // R4 count 0 = 65536
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5, 16'h6000, 16'd1, 6'd3}, // R5 R6 repeat single
    {2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 16'h6800, 16'd1, 6'd2}  // R3 R4 count 1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              cfg_start = 0, cfg_stop = 0;
  logic [ADDR_W-1:0] cfg_mem_addr = '0;
  logic [ADDR_W-1:0] cfg_io_addr = IO_ADDR;
  logic [CNT_W-1:0]  cfg_count = '0;
  logic [1:0]        cfg_mode = 2'b00;
  logic              cfg_word = 0, cfg_dec = 0, cfg_to_mem = 0, cfg_single = 0;
  logic [3:0]        cfg_src = '0;
  logic [5:0]        evt_timer = '0;
  logic              evt_tx = 0, evt_rx = 0, evt_adc = 0, ext_req = 0;
  logic              bus_req, bus_wr, bus_word, dack, busy, done_irq;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic              bus_ack = 0;

  logic              a_req, a_wr, a_word, a_dack, a_busy, a_done;
  logic [ADDR_W-1:0] a_addr;
  logic [DATA_W-1:0] a_wdata;

  dma_short_chan #(.IS_CHAN_B(1'b1)) uut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_stop(cfg_stop),
    .cfg_mem_addr(cfg_mem_addr), .cfg_io_addr(cfg_io_addr), .cfg_count(cfg_count),
    .cfg_mode(cfg_mode), .cfg_word(cfg_word), .cfg_dec(cfg_dec),
    .cfg_to_mem(cfg_to_mem), .cfg_single(cfg_single), .cfg_src(cfg_src),
    .evt_timer(evt_timer), .evt_tx(evt_tx), .evt_rx(evt_rx), .evt_adc(evt_adc),
    .ext_req(ext_req), .bus_req(bus_req), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .dack(dack), .busy(busy), .done_irq(done_irq));

  dma_short_chan #(.IS_CHAN_B(1'b0)) uut_a (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_stop(cfg_stop),
    .cfg_mem_addr(cfg_mem_addr), .cfg_io_addr(cfg_io_addr), .cfg_count(cfg_count),
    .cfg_mode(cfg_mode), .cfg_word(cfg_word), .cfg_dec(cfg_dec),
    .cfg_to_mem(cfg_to_mem), .cfg_single(cfg_single), .cfg_src(cfg_src),
    .evt_timer(evt_timer), .evt_tx(evt_tx), .evt_rx(evt_rx), .evt_adc(evt_adc),
    .ext_req(ext_req), .bus_req(a_req), .bus_wr(a_wr), .bus_word(a_word),
    .bus_addr(a_addr), .bus_wdata(a_wdata), .bus_rdata(16'h0000),
    .bus_ack(a_req), .dack(a_dack), .busy(a_busy), .done_irq(a_done));

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // phase log written by the responder
  logic [ADDR_W-1:0] log_addr  [512];
  logic              log_wr    [512];
  logic              log_word  [512];
  logic              log_dack  [512];
  logic [DATA_W-1:0] log_wdata [512];
  int phase_total = 0;
  int a_phases = 0;
  int a_dacks  = 0;

  function automatic logic [DATA_W-1:0] mdat(input logic [ADDR_W-1:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
    end else if (bus_req) begin
      log_addr[phase_total % 512]  = bus_addr;
      log_wr[phase_total % 512]    = bus_wr;
      log_word[phase_total % 512]  = bus_word;
      log_dack[phase_total % 512]  = dack;
      log_wdata[phase_total % 512] = bus_wdata;
      phase_total = phase_total + 1;
      bus_rdata = mdat(bus_addr);
      bus_ack = 1'b1;
    end else begin
      bus_ack = 1'b0;
    end
    if (!rst && a_req) begin
      a_phases = a_phases + 1;
      if (a_dack) a_dacks = a_dacks + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_chan(input logic [1:0] mode, input logic word, input logic dec,
                            input logic to_mem, input logic single, input logic [3:0] src,
                            input logic [ADDR_W-1:0] maddr, input logic [CNT_W-1:0] cnt);
    @(negedge clk);
    cfg_mode = mode; cfg_word = word; cfg_dec = dec; cfg_to_mem = to_mem;
    cfg_single = single; cfg_src = src; cfg_mem_addr = maddr; cfg_count = cnt;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic pulse_src(input int s);
    @(negedge clk);
    if (s < 6) evt_timer[s] = 1'b1;
    else if (s == 6) evt_tx = 1'b1;
    else if (s == 7) evt_rx = 1'b1;
    else if (s == 8) evt_adc = 1'b1;
    else ext_req = 1'b1;
    @(negedge clk);
    evt_timer = '0; evt_tx = 0; evt_rx = 0; evt_adc = 0; ext_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!bus_req && !dack, "R11 bus idle after reset", {bus_req, dack}, 0);
    chk(!busy && !done_irq, "R11 busy/done low after reset", {busy, done_irq}, 0);

    // vector walk: R1 R2 R3 R4 R5 R6 R9
    for (int v = 0; v < 8; v++) begin
      logic [47:0] vec;
      logic [1:0] mode; logic word, dec, tom, sgl; logic [3:0] src;
      logic [ADDR_W-1:0] a, a0, srca, dsta; int c, c0, np; bit done;
      logic [ADDR_W-1:0] ea [32]; logic ew [32]; logic ed [32]; logic [DATA_W-1:0] edat [32];
      vec = VECS[v];
      mode = vec[47:46]; word = vec[45]; dec = vec[44]; tom = vec[43]; sgl = vec[42];
      src = vec[41:38]; a0 = {8'h00, vec[37:22]};
      c0 = (vec[21:6] == 16'd0) ? 65536 : int'(vec[21:6]);
      start_chan(mode, word, dec, tom, sgl, src, a0, vec[21:6]);
      base = phase_total;
      for (int r = 0; r < int'(vec[5:0]); r++) begin
        pulse_src(int'(src));
        wait_cyc(8);
      end
      a = a0; c = c0; np = 0; done = 0;
      for (int r = 0; r < int'(vec[5:0]); r++) begin
        if (!done) begin
          if (sgl) begin
            ea[np] = a; ew[np] = tom; ed[np] = 1'b1; edat[np] = '0; np++;
          end else begin
            srca = tom ? IO_ADDR : a;
            dsta = tom ? a : IO_ADDR;
            ea[np] = srca; ew[np] = 1'b0; ed[np] = 1'b0; edat[np] = '0; np++;
            ea[np] = dsta; ew[np] = 1'b1; ed[np] = 1'b0;
            edat[np] = word ? mdat(srca) : {8'h00, mdat(srca)[7:0]}; np++;
          end
          if (mode == 2'b00 || mode == 2'b10)
            a = dec ? a - (word ? 24'd2 : 24'd1) : a + (word ? 24'd2 : 24'd1);
          c--;
          if (c == 0) begin
            if (mode == 2'b10) begin a = a0; c = c0; end
            else done = 1;
          end
        end
      end
      chk(phase_total - base == np, $sformatf("R4 vec%0d phase count", v), phase_total - base, np);
      for (int p = 0; p < np && p < phase_total - base; p++) begin
        int k;
        k = (base + p) % 512;
        chk(log_addr[k] == ea[p], $sformatf("R2 vec%0d phase%0d addr", v, p), log_addr[k], ea[p]);
        chk(log_wr[k] == ew[p] && log_dack[k] == ed[p],
            $sformatf("R6 vec%0d phase%0d wr/dack", v, p), {log_wr[k], log_dack[k]}, {ew[p], ed[p]});
        chk(log_word[k] == word, $sformatf("R1 vec%0d phase%0d size", v, p), log_word[k], word);
        if (ew[p] && !ed[p])
          chk(log_wdata[k] == edat[p], $sformatf("R1 vec%0d phase%0d data", v, p), log_wdata[k], edat[p]);
      end
      chk(done_irq == done, $sformatf("R4 R5 vec%0d done_irq", v), done_irq, done);
      chk(busy == !done, $sformatf("R4 R5 vec%0d busy", v), busy, !done);
    end

    // R8: request while disabled is dropped
    @(negedge clk); cfg_stop = 1'b1; @(negedge clk); cfg_stop = 1'b0;
    cfg_src = 4'd0;
    base = phase_total;
    pulse_src(0);
    wait_cyc(4);
    start_chan(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 24'h007000, 16'd10);
    wait_cyc(10);
    chk(phase_total == base, "R8 no transfer from dropped request", phase_total - base, 0);
    @(negedge clk); cfg_stop = 1'b1; @(negedge clk); cfg_stop = 1'b0;
    pulse_src(0);
    wait_cyc(10);
    chk(phase_total == base && !busy, "R8 stopped channel ignores request", phase_total - base, 0);

    // R7: pulse during an active unit is held
    start_chan(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 24'h007000, 16'd10);
    base = phase_total;
    pulse_src(0);
    while (!bus_req) @(negedge clk);
    pulse_src(0);
    wait_cyc(12);
    chk(phase_total - base == 4, "R7 held request served", phase_total - base, 4);
    chk(log_addr[(base + 2) % 512] == 24'h007001, "R7 second unit address",
        log_addr[(base + 2) % 512], 24'h007001);

    // R9: only the selected source triggers
    start_chan(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 24'h007100, 16'd10);
    base = phase_total;
    pulse_src(1); pulse_src(7); pulse_src(9);
    wait_cyc(8);
    chk(phase_total == base, "R9 unselected sources ignored", phase_total - base, 0);
    pulse_src(2);
    wait_cyc(8);
    chk(phase_total - base == 2, "R9 selected source triggers", phase_total - base, 2);

    // R10: channel A ignores the external pin and single-address mode
    start_chan(2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9, 24'h007200, 16'd10);
    base = a_phases;
    pulse_src(9);
    wait_cyc(8);
    chk(a_phases == base, "R10 channel A ignores ext_req", a_phases - base, 0);
    start_chan(2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 24'h007200, 16'd10);
    base = a_phases;
    pulse_src(0);
    wait_cyc(8);
    chk(a_phases - base == 2 && a_dacks == 0, "R10 channel A runs dual-address",
        a_phases - base, 2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule